// File: doc/BRIEF.md
# Fractional-N Divider Controller

This block is the digital heart of a fractional-N frequency synthesizer. It runs on the VCO-side clock. It holds a programmable feedback divider that normally divides by an integer N, and a four-digit decimal fraction accumulator that steps once per reference-clock enable pulse. Whenever the decimal sum passes 1.0000, the accumulator arms a one-shot request. The divider serves that request at its next reload by dividing by N+1 for exactly one division period, and so swallows one extra VCO cycle. Averaged over many reference periods, the division ratio is therefore N plus the fraction.

The running residue of the accumulator is driven out as a BCD word. An external DAC uses it to cancel the ramp that the phase detector sees between swallow events. The integer ratio and the fraction are sampled only when the divider reloads, so a division period in progress is never cut short. The fraction is ignored if any of its digits is not a decimal digit. In a closed loop the reference enable is aligned with the divided feedback pulse. The integer ratio must be at least 2.

Top module: `fracn_div_ctrl`

## Requirements
- R1: With no swallow request armed, the divider reloads with N on reaching terminal count, so `div_pulse` rises once every N clocks and is high for exactly one clock.
- R2: `frac_in` holds four BCD digits, each with a value from 0 to 9. Bits [15:12] carry the weight 10^-1 and bits [3:0] carry 10^-4. On every clock in which `ref_tick` is high, the accepted fraction is added in decimal to the residue.
- R3: A decimal carry out of the most significant digit makes exactly the next division period N+1 clocks long. The period after that returns to N.
- R4: `swallow_flag` is high for one clock. It is high together with the `div_pulse` that starts an N+1 period, and low at all other times.
- R5: `acc_word` shows the residue in the same BCD layout as `frac_in`. It changes only in the clock after a clock in which `ref_tick` is high. After j reference ticks from reset with a fixed fraction F, it equals (j·F) mod 10^4.
- R6: A fraction in which any digit exceeds 9 is rejected, and the previously accepted fraction stays in use.
- R7: A new `n_in` and `frac_in` are sampled only when the divider reloads. A change made in the middle of a period does not alter the length of that period.
- R8: With `ref_tick` tied to `div_pulse`, any W consecutive division periods span N·W + F·W/10^4 clocks whenever F·W is a multiple of 10^4. For W = 10^4 this gives exactly N·10^4 + F.
- R9: A synchronous active-high reset clears `div_pulse`, `swallow_flag`, `acc_word` and any armed request. The first `div_pulse` appears in the clock after the first edge at which reset is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | VCO-side clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | Reference enable pulse, one clock wide, that advances the accumulator |
| n_in | input | N_W | Integer division ratio N (at least 2) |
| frac_in | input | 4·DIGITS | Fractional part as BCD digits, most significant digit in the top nibble |
| div_pulse | output | 1 | Divided feedback pulse, one clock wide |
| swallow_flag | output | 1 | Marks a division period of N+1 |
| acc_word | output | 4·DIGITS | BCD residue for the phase-error-cancelling DAC |

## Verification
A corrupted residue shows on `acc_word` in the clock after the next reference tick. It also shows as a swallow event placed in the wrong period, which becomes visible at the next `div_pulse` as a period of the wrong length or a misplaced `swallow_flag`. A lost or duplicated swallow request changes the total clock count of a measurement window by exactly one. For that reason the windows are chosen so that the fraction contributes a whole number of cycles, and the bench compares the total exactly rather than within a tolerance. A reload value that is off by one shows on the very next period.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
  localparam int DIGIT_W = 4;
  localparam int DIGIT_MAX = 9;

  typedef logic [DIGIT_W-1:0] bcd_digit_t;

  function automatic logic digit_ok(input bcd_digit_t d);
    return d <= bcd_digit_t'(DIGIT_MAX);
  endfunction
endpackage

// File: rtl/bcd_digit_add.sv
module bcd_digit_add
  import fracn_pkg::*;
(
  input  bcd_digit_t a,
  input  bcd_digit_t b,
  input  logic       cin,
  output bcd_digit_t sum,
  output logic       cout
);
  logic [DIGIT_W:0] raw;

  always_comb begin
    raw = {1'b0, a} + {1'b0, b} + {{DIGIT_W{1'b0}}, cin};
    if (raw > (DIGIT_W+1)'(DIGIT_MAX)) begin
      sum  = bcd_digit_t'(raw - (DIGIT_W+1)'(DIGIT_MAX + 1));
      cout = 1'b1;
    end else begin
      sum  = bcd_digit_t'(raw);
      cout = 1'b0;
    end
  end
endmodule

// File: rtl/bcd_frac_accum.sv
module bcd_frac_accum
  import fracn_pkg::*;
#(
  parameter int DIGITS = 4,
  localparam int FRAC_W = DIGITS * DIGIT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              load,
  input  logic [FRAC_W-1:0] frac_in,
  output logic [FRAC_W-1:0] acc,
  output logic              ovf
);
  logic [FRAC_W-1:0] frac_act;
  logic [FRAC_W-1:0] sum;
  logic [DIGITS:0]   cy;
  logic [DIGITS-1:0] dig_ok;

  assign cy[0] = 1'b0;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    bcd_digit_add u_add (
      .a   (acc[g*DIGIT_W +: DIGIT_W]),
      .b   (frac_act[g*DIGIT_W +: DIGIT_W]),
      .cin (cy[g]),
      .sum (sum[g*DIGIT_W +: DIGIT_W]),
      .cout(cy[g+1])
    );
    assign dig_ok[g] = digit_ok(frac_in[g*DIGIT_W +: DIGIT_W]);
  end

  assign ovf = tick & cy[DIGITS];

  always_ff @(posedge clk) begin
    if (rst) begin
      frac_act <= '0;
      acc      <= '0;
    end else begin
      if (load && (&dig_ok)) frac_act <= frac_in;
      if (tick) acc <= sum;
    end
  end
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider #(
  parameter int N_W = 12
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N_W-1:0] n_in,
  input  logic           ovf,
  output logic           reload,
  output logic           div_pulse,
  output logic           swallow_flag
);
  logic [N_W-1:0] cnt;
  logic           pending;

  assign reload = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt          <= '0;
      pending      <= 1'b0;
      div_pulse    <= 1'b0;
      swallow_flag <= 1'b0;
    end else begin
      div_pulse    <= reload;
      swallow_flag <= reload & pending;
      pending      <= (pending & ~reload) | ovf;
      if (reload) cnt <= pending ? n_in : n_in - N_W'(1);
      else        cnt <= cnt - N_W'(1);
    end
  end
endmodule

// File: rtl/fracn_div_ctrl.sv
module fracn_div_ctrl #(
  parameter int N_W = 12,
  parameter int DIGITS = 4,
  localparam int FRAC_W = DIGITS * fracn_pkg::DIGIT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_tick,
  input  logic [N_W-1:0]    n_in,
  input  logic [FRAC_W-1:0] frac_in,
  output logic              div_pulse,
  output logic              swallow_flag,
  output logic [FRAC_W-1:0] acc_word
);
  logic reload;
  logic ovf;

  bcd_frac_accum #(.DIGITS(DIGITS)) u_accum (
    .clk    (clk),
    .rst    (rst),
    .tick   (ref_tick),
    .load   (reload),
    .frac_in(frac_in),
    .acc    (acc_word),
    .ovf    (ovf)
  );

  swallow_divider #(.N_W(N_W)) u_div (
    .clk         (clk),
    .rst         (rst),
    .n_in        (n_in),
    .ovf         (ovf),
    .reload      (reload),
    .div_pulse   (div_pulse),
    .swallow_flag(swallow_flag)
  );
endmodule

// File: rtl/fracn_div_ctrl_chk.sv
module fracn_div_ctrl_chk #(
  parameter int DIGITS = 4,
  localparam int FRAC_W = DIGITS * fracn_pkg::DIGIT_W
) (
  input logic              clk,
  input logic              rst,
  input logic              ref_tick,
  input logic              div_pulse,
  input logic              swallow_flag,
  input logic [FRAC_W-1:0] acc_word
);
  // R1
  pulse_gap_chk: assert property (@(posedge clk) disable iff (rst)
    div_pulse |=> !div_pulse);

  // R4
  swallow_align_chk: assert property (@(posedge clk) disable iff (rst)
    swallow_flag |-> div_pulse);

  // R4
  swallow_once_chk: assert property (@(posedge clk) disable iff (rst)
    swallow_flag |=> !swallow_flag);

  // R5
  acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ref_tick |=> $stable(acc_word));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!div_pulse && !swallow_flag && acc_word == '0));

  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    // R2
    digit_range_chk: assert property (@(posedge clk) disable iff (rst)
      acc_word[g*4 +: 4] <= 4'd9);
  end
endmodule

bind fracn_div_ctrl fracn_div_ctrl_chk #(.DIGITS(DIGITS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ref_tick    (ref_tick),
  .div_pulse   (div_pulse),
  .swallow_flag(swallow_flag),
  .acc_word    (acc_word)
);

// File: tb/fracn_div_ctrl_bench.sv
module fracn_div_ctrl_bench;
  localparam int N_W = 12;
  localparam int DIGITS = 4;
  localparam int FW = DIGITS * 4;
  localparam int NV = 7;
  localparam int LIMIT = 195000;

  localparam int              VEC_N [0:NV-1] = '{4, 4, 5, 9, 12, 6, 4};
  localparam logic [FW-1:0]   VEC_F [0:NV-1] = '{16'h0001, 16'h9999, 16'h1234,
                                                 16'h5000, 16'h2500, 16'h0000, 16'h0625};
  localparam int              VEC_W [0:NV-1] = '{10000, 10000, 10000, 100, 40, 50, 160};
  localparam int              VEC_C [0:NV-1] = '{40001, 49999, 51234, 950, 490, 300, 650};
  localparam int              VEC_S [0:NV-1] = '{1, 9999, 1234, 50, 10, 0, 10};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N_W-1:0] n_in = '0;
  logic [FW-1:0] frac_in = '0;
  logic          ref_tick;
  logic          div_pulse;
  logic          swallow_flag;
  logic [FW-1:0] acc_word;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  assign ref_tick = div_pulse;

  fracn_div_ctrl #(.N_W(N_W), .DIGITS(DIGITS)) u_fracn_div_ctrl (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .n_in(n_in), .frac_in(frac_in),
    .div_pulse(div_pulse), .swallow_flag(swallow_flag), .acc_word(acc_word)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic wait_pulse;
    do @(negedge clk); while (!div_pulse);
  endtask

  task automatic next_period(output int cyc);
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (!div_pulse);
  endtask

  task automatic measure(input int w, output int cyc, output int swl);
    int seen;
    repeat (3) wait_pulse();
    cyc = 0; swl = 0; seen = 0;
    while (seen < w) begin
      @(negedge clk);
      cyc++;
      if (div_pulse) seen++;
      if (swallow_flag) swl++;
    end
  endtask

  function automatic bit digits_valid(input logic [FW-1:0] v);
    for (int k = 0; k < DIGITS; k++)
      if (v[k*4 +: 4] > 4'd9) return 1'b0;
    return 1'b1;
  endfunction

  initial begin
    for (int i = 0; i < LIMIT; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", LIMIT, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cyc, swl, per;
    n_in = N_W'(4);
    frac_in = 16'h1234;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(div_pulse == 1'b0, "R9 div_pulse in reset", int'(div_pulse), 0);
    check(swallow_flag == 1'b0, "R9 swallow_flag in reset", int'(swallow_flag), 0);
    check(acc_word == '0, "R9 acc_word in reset", int'(acc_word), 0);
    rst = 1'b0;
    @(negedge clk);
    check(div_pulse == 1'b1, "R9 first pulse after release", int'(div_pulse), 1);

    // pulse 0 seen; walk pulses 1..11 with N=4, F=0.1234
    for (int j = 1; j <= 11; j++) begin
      next_period(per);
      if (j == 2) check(per == 4, "R1 plain period", per, 4);
      if (j == 5) begin
        check(acc_word == 16'h6170, "R5 residue after 5 ticks", int'(acc_word), 'h6170);
        check(swallow_flag == 1'b0, "R4 no swallow without carry", int'(swallow_flag), 0);
      end
      if (j == 9) begin
        check(acc_word == 16'h1106, "R2 decimal wrap after 9 ticks", int'(acc_word), 'h1106);
        check(swallow_flag == 1'b1, "R4 swallow marks N+1 period", int'(swallow_flag), 1);
      end
      if (j == 10) check(per == 5, "R3 swallowed period is N+1", per, 5);
      if (j == 11) check(per == 4, "R3 return to N", per, 4);
    end

    // R8 / R3 / R4: average ratio windows from the vector table
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      n_in = N_W'(VEC_N[v]);
      frac_in = VEC_F[v];
      measure(VEC_W[v], cyc, swl);
      check(cyc == VEC_C[v], $sformatf("R8 window cycles vector %0d", v), cyc, VEC_C[v]);
      check(swl == VEC_S[v], $sformatf("R3 swallow count vector %0d", v), swl, VEC_S[v]);
    end

    // R6: invalid fraction rejected, previous one kept
    @(negedge clk);
    n_in = N_W'(4);
    frac_in = 16'h2500;
    measure(4, cyc, swl);
    check(cyc == 17, "R6 baseline window", cyc, 17);
    frac_in = 16'h9F00;
    measure(4, cyc, swl);
    check(cyc == 17, "R6 invalid fraction ignored", cyc, 17);
    check(digits_valid(acc_word), "R6 residue digits stay decimal", int'(acc_word), 0);

    // R7: mid-period change does not truncate current period
    frac_in = 16'h0000;
    n_in = N_W'(8);
    repeat (3) wait_pulse();
    repeat (2) @(negedge clk);
    n_in = N_W'(3);
    per = 2;
    do begin @(negedge clk); per++; end while (!div_pulse);
    check(per == 8, "R7 period in progress kept", per, 8);
    next_period(per);
    check(per == 3, "R7 new N at reload", per, 3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule